// File: doc/BRIEF.md
# Strobe-Controlled External Data Port

This block puts an 8-bit data register behind a two-level register window on an ISA-style I/O bus. Software first writes a primary index through the index port. Primary index 2Eh makes the data port reach an extended-index selector. Primary index 2Fh makes the data port reach whichever extended register that selector names. Extended index 0Ah is the data register. Extended index 0Bh is a mode-control register.

Two bits of the mode-control register set what the data register does. It can be a plain scratchpad. It can be an external read port: a general-purpose active-low strobe enables an outside buffer, and the bus read returns the external data. It can be an external write port: the same strobe acts as a latch enable, so an outside register captures the bus data. Software should treat only the low nibble as significant, but all 8 bits are stored.

Bus strobes, the port select and the data lines are synchronous to `clk_i`. A write commits on the first clock edge that sees its strobe low. Read data is combinational while the read strobe is held. The general-purpose strobe comes from a register.

Top module: `ext_data_port`

## Requirements
- R1: After reset, the index, extended-index, data and mode registers read 00h and `gp_strobe_no` is high.
- R2: A write with `port_sel_i`=0 loads the primary index. A read with `port_sel_i`=0 returns it.
- R3: With primary index 2Eh, data-port writes load the extended-index selector and data-port reads return it.
- R4: Mode bits {ctrl[4],ctrl[3]}=00 (scratchpad): the data register (index 2Fh, extended 0Ah) stores writes, reads return the stored value, and `gp_strobe_no` stays high.
- R5: Mode 01 (read port): while a data-register read is held, `gp_strobe_no` is low from the first clock edge after `ior_ni` falls, and `bus_data_o` equals `ext_data_i`. The strobe is high again at the first edge after `ior_ni` rises.
- R6: Mode 10 (write port): while a data-register write is held, `gp_strobe_no` is low from the first edge after `iow_ni` falls, and the register stores the bus data. Later reads return the stored value, not `ext_data_i`. The strobe is high again at the first edge after `iow_ni` rises.
- R7: Mode 11 (reserved) behaves as a scratchpad and never asserts `gp_strobe_no`.
- R8: `gp_strobe_no` is never asserted for accesses that do not select the data register. This covers the index port, other primary indices and other extended indices.
- R9: Extended index 0Bh is an 8-bit read/write mode register. Its bit 4 enables the strobe on writes and its bit 3 enables the strobe on reads.
- R10: A data-port read returns 00h when the primary index is neither 2Eh nor 2Fh, or when, under 2Fh, the extended index is neither 0Ah nor 0Bh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_sel_i | input | 1 | 0 selects the index port, 1 selects the data port |
| iow_ni | input | 1 | Bus I/O write strobe, active low |
| ior_ni | input | 1 | Bus I/O read strobe, active low |
| bus_data_i | input | 8 | Bus write data (upper byte lines) |
| bus_data_o | output | 8 | Bus read data, valid while `ior_ni` is low |
| ext_data_i | input | 8 | Data from the external buffer |
| gp_strobe_no | output | 1 | General-purpose strobe to the external buffer or latch, active low |

## Verification
`bus_data_o` is combinational, so a read result is due as soon as the strobe is driven. The bench samples it at the next falling clock edge. A register write lands at the first rising edge with the write strobe low. `gp_strobe_no` changes at that same rising edge and releases one rising edge after the bus strobe rises. Each access task therefore drives its inputs on a falling edge and checks the strobe level at the following falling edge. It checks the release one falling edge after the bus strobe is lifted. Expected values come from a bench-side register model that is updated only after each access has been checked.

// File: rtl/ext_data_port_pkg.sv
package ext_data_port_pkg;
  typedef enum logic [1:0] {
    MODE_SCRATCH = 2'b00,
    MODE_RD_PORT = 2'b01,
    MODE_WR_PORT = 2'b10,
    MODE_RSVD    = 2'b11
  } xport_mode_e;
endpackage

// File: rtl/ext_data_port_wr_det.sv
module ext_data_port_wr_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic iow_ni,
  output logic wr_pulse_o
);
  logic iow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) iow_q <= 1'b1;
    else         iow_q <= iow_ni;
  end

  // one commit per bus write, on its first low cycle
  assign wr_pulse_o = !iow_ni && iow_q;
endmodule

// File: rtl/ext_data_port_regs.sv
module ext_data_port_regs #(
  parameter int          DW        = 8,
  parameter logic [7:0]  IDX_XSEL  = 8'h2E,
  parameter logic [7:0]  IDX_XWIN  = 8'h2F,
  parameter logic [7:0]  XIDX_DATA = 8'h0A,
  parameter logic [7:0]  XIDX_CTRL = 8'h0B
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          port_sel_i,
  input  logic          wr_pulse_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ext_sel_i,
  input  logic [DW-1:0] ext_data_i,
  output logic [DW-1:0] rdata_o,
  output logic          data_hit_o,
  output logic [DW-1:0] idx_o,
  output logic [DW-1:0] xidx_o,
  output logic [DW-1:0] ctrl_o
);
  logic [DW-1:0] idx_q, xidx_q, data_q, ctrl_q;
  logic sel_xsel, sel_xwin, sel_data, sel_ctrl;

  assign sel_xsel = port_sel_i && (idx_q == DW'(IDX_XSEL));
  assign sel_xwin = port_sel_i && (idx_q == DW'(IDX_XWIN));
  assign sel_data = sel_xwin && (xidx_q == DW'(XIDX_DATA));
  assign sel_ctrl = sel_xwin && (xidx_q == DW'(XIDX_CTRL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      xidx_q <= '0;
      data_q <= '0;
      ctrl_q <= '0;
    end else if (wr_pulse_i) begin
      if (!port_sel_i) idx_q  <= wdata_i;
      if (sel_xsel)    xidx_q <= wdata_i;
      if (sel_data)    data_q <= wdata_i;
      if (sel_ctrl)    ctrl_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (!port_sel_i)   rdata_o = idx_q;
    else if (sel_xsel) rdata_o = xidx_q;
    else if (sel_data) rdata_o = ext_sel_i ? ext_data_i : data_q;
    else if (sel_ctrl) rdata_o = ctrl_q;
  end

  assign data_hit_o = sel_data;
  assign idx_o      = idx_q;
  assign xidx_o     = xidx_q;
  assign ctrl_o     = ctrl_q;
endmodule

// File: rtl/ext_data_port_strobe.sv
module ext_data_port_strobe
  import ext_data_port_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        hit_i,
  input  xport_mode_e mode_i,
  input  logic        iow_ni,
  input  logic        ior_ni,
  output logic        strobe_no
);
  logic fire;

  // reserved and scratchpad modes never fire
  assign fire = hit_i && (((mode_i == MODE_WR_PORT) && !iow_ni) ||
                          ((mode_i == MODE_RD_PORT) && !ior_ni));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_no <= 1'b1;
    else         strobe_no <= !fire;
  end
endmodule

// File: rtl/ext_data_port.sv
module ext_data_port
  import ext_data_port_pkg::*;
#(
  parameter int         DW        = 8,
  parameter logic [7:0] IDX_XSEL  = 8'h2E,
  parameter logic [7:0] IDX_XWIN  = 8'h2F,
  parameter logic [7:0] XIDX_DATA = 8'h0A,
  parameter logic [7:0] XIDX_CTRL = 8'h0B,
  parameter int         WR_BIT    = 4,
  parameter int         RD_BIT    = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          port_sel_i,
  input  logic          iow_ni,
  input  logic          ior_ni,
  input  logic [DW-1:0] bus_data_i,
  output logic [DW-1:0] bus_data_o,
  input  logic [DW-1:0] ext_data_i,
  output logic          gp_strobe_no
);
  logic          wr_pulse, data_hit;
  logic [DW-1:0] idx_w, xidx_w, ctrl_w;
  xport_mode_e   mode;

  assign mode = xport_mode_e'({ctrl_w[WR_BIT], ctrl_w[RD_BIT]});

  ext_data_port_wr_det u_wr_det (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .iow_ni     (iow_ni),
    .wr_pulse_o (wr_pulse)
  );

  ext_data_port_regs #(
    .DW(DW), .IDX_XSEL(IDX_XSEL), .IDX_XWIN(IDX_XWIN),
    .XIDX_DATA(XIDX_DATA), .XIDX_CTRL(XIDX_CTRL)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .port_sel_i (port_sel_i),
    .wr_pulse_i (wr_pulse),
    .wdata_i    (bus_data_i),
    .ext_sel_i  (mode == MODE_RD_PORT),
    .ext_data_i (ext_data_i),
    .rdata_o    (bus_data_o),
    .data_hit_o (data_hit),
    .idx_o      (idx_w),
    .xidx_o     (xidx_w),
    .ctrl_o     (ctrl_w)
  );

  ext_data_port_strobe u_strobe (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hit_i     (data_hit),
    .mode_i    (mode),
    .iow_ni    (iow_ni),
    .ior_ni    (ior_ni),
    .strobe_no (gp_strobe_no)
  );
endmodule

// File: rtl/ext_data_port_chk.sv
module ext_data_port_chk #(
  parameter int         DW        = 8,
  parameter logic [7:0] IDX_XWIN  = 8'h2F,
  parameter logic [7:0] XIDX_DATA = 8'h0A,
  parameter int         WR_BIT    = 4,
  parameter int         RD_BIT    = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          port_sel_i,
  input logic          iow_ni,
  input logic          ior_ni,
  input logic [DW-1:0] idx_i,
  input logic [DW-1:0] xidx_i,
  input logic [DW-1:0] ctrl_i,
  input logic [DW-1:0] ext_data_i,
  input logic [DW-1:0] bus_data_o,
  input logic          gp_strobe_no
);
  logic       hit;
  logic [1:0] md;
  assign hit = port_sel_i && (idx_i == DW'(IDX_XWIN)) && (xidx_i == DW'(XIDX_DATA));
  assign md  = {ctrl_i[WR_BIT], ctrl_i[RD_BIT]};

  a_r4_scratch_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (md == 2'b00) |=> gp_strobe_no);
  a_r7_rsvd_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (md == 2'b11) |=> gp_strobe_no);
  a_r8_needs_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |=> gp_strobe_no);
  a_r5_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iow_ni && ior_ni) |=> gp_strobe_no);
  a_r5_rd_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (md == 2'b01 && hit && !ior_ni) |=> !gp_strobe_no);
  a_r5_rd_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (md == 2'b01 && hit && !ior_ni) |-> (bus_data_o == ext_data_i));
  a_r6_wr_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (md == 2'b10 && hit && !iow_ni) |=> !gp_strobe_no);
endmodule

bind ext_data_port ext_data_port_chk #(
  .DW(DW), .IDX_XWIN(IDX_XWIN), .XIDX_DATA(XIDX_DATA), .WR_BIT(WR_BIT), .RD_BIT(RD_BIT)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .port_sel_i   (port_sel_i),
  .iow_ni       (iow_ni),
  .ior_ni       (ior_ni),
  .idx_i        (idx_w),
  .xidx_i       (xidx_w),
  .ctrl_i       (ctrl_w),
  .ext_data_i   (ext_data_i),
  .bus_data_o   (bus_data_o),
  .gp_strobe_no (gp_strobe_no)
);

// File: tb/tb_ext_data_port.sv
`timescale 1ns/1ps
module tb_ext_data_port;
  logic       clk_i = 1'b0, rst_ni = 1'b0, port_sel_i = 1'b0, iow_ni = 1'b1, ior_ni = 1'b1;
  logic [7:0] bus_data_i = '0, ext_data_i = '0;
  logic [7:0] bus_data_o;
  logic       gp_strobe_no;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;
  logic [7:0] m_idx = '0, m_xidx = '0, m_data = '0, m_ctrl = '0;

  always #2.5 clk_i = ~clk_i;

  ext_data_port dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .port_sel_i(port_sel_i), .iow_ni(iow_ni),
    .ior_ni(ior_ni), .bus_data_i(bus_data_i), .bus_data_o(bus_data_o),
    .ext_data_i(ext_data_i), .gp_strobe_no(gp_strobe_no)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] mode_f();
    return {m_ctrl[4], m_ctrl[3]};
  endfunction

  function automatic logic hit_f(logic port);
    return port && m_idx == 8'h2F && m_xidx == 8'h0A;
  endfunction

  function automatic string tag_f(logic port);
    if (!hit_f(port)) return "R8";
    case (mode_f())
      2'b00: return "R4";
      2'b01: return "R5";
      2'b10: return "R6";
      default: return "R7";
    endcase
  endfunction

  function automatic logic [7:0] exp_rd(logic port, logic [7:0] ext);
    if (!port) return m_idx;
    if (m_idx == 8'h2E) return m_xidx;
    if (m_idx == 8'h2F && m_xidx == 8'h0A) return (mode_f() == 2'b01) ? ext : m_data;
    if (m_idx == 8'h2F && m_xidx == 8'h0B) return m_ctrl;
    return 8'h00;
  endfunction

  function automatic string rd_tag_f(logic port);
    if (!port) return "R2";
    if (m_idx == 8'h2E) return "R3";
    if (m_idx == 8'h2F && m_xidx == 8'h0A) return tag_f(port);
    if (m_idx == 8'h2F && m_xidx == 8'h0B) return "R9";
    return "R10";
  endfunction

  task automatic do_wr(logic port, logic [7:0] d);
    logic  exp_s;
    string t;
    @(negedge clk_i);
    port_sel_i = port; bus_data_i = d; iow_ni = 1'b0;
    exp_s = !(hit_f(port) && mode_f() == 2'b10);
    t = tag_f(port);
    @(negedge clk_i);
    chk({t, " wr strobe"}, {7'b0, gp_strobe_no}, {7'b0, exp_s});
    if (!port) m_idx = d;
    else if (m_idx == 8'h2E) m_xidx = d;
    else if (m_idx == 8'h2F && m_xidx == 8'h0A) m_data = d;
    else if (m_idx == 8'h2F && m_xidx == 8'h0B) m_ctrl = d;
    iow_ni = 1'b1;
    @(negedge clk_i);
    chk("R6 wr release", {7'b0, gp_strobe_no}, 8'h01);
  endtask

  task automatic do_rd(logic port, logic [7:0] ext);
    logic       exp_s;
    logic [7:0] exp_d;
    string      t, td;
    @(negedge clk_i);
    port_sel_i = port; ext_data_i = ext; ior_ni = 1'b0;
    exp_s = !(hit_f(port) && mode_f() == 2'b01);
    exp_d = exp_rd(port, ext);
    t = tag_f(port); td = rd_tag_f(port);
    @(negedge clk_i);
    chk({td, " rd data"}, bus_data_o, exp_d);
    chk({t, " rd strobe"}, {7'b0, gp_strobe_no}, {7'b0, exp_s});
    ior_ni = 1'b1;
    @(negedge clk_i);
    chk("R5 rd release", {7'b0, gp_strobe_no}, 8'h01);
  endtask

  task automatic goto(logic [7:0] xi);
    do_wr(1'b0, 8'h2E); do_wr(1'b1, xi); do_wr(1'b0, 8'h2F);
  endtask

  initial begin
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    @(negedge clk_i);
    chk("R1 strobe idle", {7'b0, gp_strobe_no}, 8'h01);
    do_rd(1'b0, 8'hFF);
    do_wr(1'b0, 8'h2F);
    do_rd(1'b1, 8'hA5);               // R1 data reg 00 (xidx 00 -> unmapped)
    do_wr(1'b0, 8'h2E);
    do_rd(1'b1, 8'h00);               // R3 xidx reset 00
    goto(8'h0B); do_rd(1'b1, 8'h77);  // R1/R9 ctrl reset 00
    goto(8'h0A);
    do_wr(1'b1, 8'h5A); do_rd(1'b1, 8'hC3);        // R4 scratchpad
    goto(8'h0B); do_wr(1'b1, 8'h08); do_rd(1'b1, 8'h00); // R9 read mode
    do_rd(1'b1, 8'h99);                            // R8 ctrl read, no strobe
    goto(8'h0A); do_rd(1'b1, 8'hC3); do_rd(1'b1, 8'h3E); // R5
    do_rd(1'b0, 8'h11);                            // R8 index port
    goto(8'h0B); do_wr(1'b1, 8'h10);
    goto(8'h0A); do_wr(1'b1, 8'h3C); do_rd(1'b1, 8'hE1); // R6
    goto(8'h0B); do_wr(1'b1, 8'h18);
    goto(8'h0A); do_wr(1'b1, 8'h96); do_rd(1'b1, 8'h42); // R7
    do_wr(1'b0, 8'h55); do_rd(1'b1, 8'hAA);        // R10 unmapped index
    goto(8'h0C); do_rd(1'b1, 8'hAA);               // R10 unmapped xidx
    void'($urandom(32'h5EED));
    for (int i = 0; i < 600; i++) begin
      int unsigned op = $urandom_range(0, 6);
      logic [7:0] v = 8'($urandom);
      case (op)
        0: begin
          int unsigned c = $urandom_range(0, 2);
          do_wr(1'b0, c == 0 ? 8'h2E : c == 1 ? 8'h2F : v);
        end
        1: begin
          int unsigned c = $urandom_range(0, 2);
          goto(c == 0 ? 8'h0A : c == 1 ? 8'h0B : v);
        end
        2, 3: do_wr(1'b1, v);
        4, 5: do_rd(1'b1, v);
        default: do_rd(1'b0, v);
      endcase
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule